// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into one pending vector and drives two outputs from it: a normal interrupt request and a fast interrupt request. Each output has its own enable mask over the same pending vector. Software changes a mask by writing a set word, which ORs bits in, or a clear word, which removes bits. Neither write disturbs the other bits of the mask.

Line 0 can also be raised and lowered by software through a pair of set and clear words. This provides a software-triggered interrupt that shares line 0 with the hardware source. Reads return the masked status and the raw pending vector for each output path. An access to a word that does not support it returns zero, changes nothing and pulses an error flag. Several instances can be cascaded by wiring one instance's request output into another instance's input line. That wiring is outside the block.

The register port is word-addressed with a 4-bit word index. Read data is registered and appears the cycle after the read strobe. The hardware lines are sampled into a register once per cycle. Both request outputs are combinational from registered state.

Top module: `intc_dual`

## Requirements
- R1: After reset both enable masks and the software bit are zero, `irq_o` and `fiq_o` are low, and `rdata_o` and `err_o` are zero.
- R2: Reading word 1 or word 9 returns the pending vector. Bit i is the value of `src_i[i]` sampled at the previous clock edge. Bit 0 also includes the software bit.
- R3: Writing word 2 ORs `wdata_i` into the normal enable mask, and reading word 2 returns that mask. Word 10 does the same for the fast enable mask.
- R4: Writing word 3 clears the bits of the normal enable mask that are set in `wdata_i`. Word 11 does the same for the fast enable mask.
- R5: Reading word 0 returns the pending vector AND the normal mask. Reading word 8 returns the pending vector AND the fast mask.
- R6: `irq_o` is high exactly when the pending vector AND the normal mask is non-zero, and `fiq_o` follows the same rule with the fast mask. Both outputs respond in the cycle after `src_i` or a mask changes.
- R7: A write to word 4 with bit 0 set raises the software bit, and a write to word 5 with bit 0 set lowers it. When bit 0 of the written value is 0, neither write has any effect. Reading word 4 returns the software bit in bit 0.
- R8: Pending bit 0 is the OR of the sampled `src_i[0]` and the software bit. Lowering the software bit does not hide an active hardware line 0.
- R9: The following accesses are invalid: writes to words 0, 1, 8 and 9; reads of words 3, 5 and 11; and any access to words 6, 7 or 12 to 15. An invalid access changes no state. An invalid read returns zero. In both cases `err_o` is high for the one cycle after the access.
- R10: Read data appears on `rdata_o` in the cycle after `rd_en_i` and holds until the next read. If `wr_en_i` and `rd_en_i` are both asserted, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Level interrupt lines |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Word index |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse after an invalid access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its defaults, 32 lines over a 32-bit data word. This puts every bit of both masks and of the pending vector in range of random set and clear writes. Because the word index is 4 bits wide, random addresses reach the unused words 6, 7 and 12 to 15 as well as the write-only and read-only words. A bench model predicts both masks, the software bit and the outputs. Directed sequences cover line 0 driven by both hardware and software, set and clear writes with bit 0 low, and a write and read issued together.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] A_IRQ_STAT = 4'd0;
  localparam logic [REG_AW-1:0] A_IRQ_RAW  = 4'd1;
  localparam logic [REG_AW-1:0] A_IRQ_EN   = 4'd2;
  localparam logic [REG_AW-1:0] A_IRQ_CLR  = 4'd3;
  localparam logic [REG_AW-1:0] A_SW_SET   = 4'd4;
  localparam logic [REG_AW-1:0] A_SW_CLR   = 4'd5;
  localparam logic [REG_AW-1:0] A_FIQ_STAT = 4'd8;
  localparam logic [REG_AW-1:0] A_FIQ_RAW  = 4'd9;
  localparam logic [REG_AW-1:0] A_FIQ_EN   = 4'd10;
  localparam logic [REG_AW-1:0] A_FIQ_CLR  = 4'd11;
  localparam int unsigned NUM_PATH = 2;   // 0: normal, 1: fast
endpackage

// File: rtl/intc_mask.sv
module intc_mask #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (set_i) mask_q <= mask_q | bits_i;
    else if (clr_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/intc_level.sv
module intc_level #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         sw_set_i,
  input  logic         sw_clr_i,
  output logic [N-1:0] level_o,
  output logic         sw_o
);
  logic [N-1:0] hw_q;
  logic         sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q <= '0;
      sw_q <= 1'b0;
    end else begin
      hw_q <= src_i;
      if (sw_set_i)      sw_q <= 1'b1;
      else if (sw_clr_i) sw_q <= 1'b0;
    end
  end

  // line 0 shared by hardware and software
  always_comb begin
    level_o    = hw_q;
    level_o[0] = hw_q[0] | sw_q;
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N-1:0]      level_i,
  input  logic [N-1:0]      irq_mask_i,
  input  logic [N-1:0]      fiq_mask_i,
  input  logic              sw_i,
  output logic              irq_set_o,
  output logic              irq_clr_o,
  output logic              fiq_set_o,
  output logic              fiq_clr_o,
  output logic              sw_set_o,
  output logic              sw_clr_o,
  output logic [DW-1:0]     rdata_o,
  output logic              err_o
);
  logic          rd_act;
  logic          rd_ok, wr_ok;
  logic [N-1:0]  rd_bits;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_q;
  logic          err_q;

  assign rd_act = rd_en_i & ~wr_en_i;

  always_comb begin
    rd_ok   = 1'b1;
    rd_bits = '0;
    case (addr_i)
      A_IRQ_STAT: rd_bits = level_i & irq_mask_i;
      A_IRQ_RAW:  rd_bits = level_i;
      A_IRQ_EN:   rd_bits = irq_mask_i;
      A_SW_SET:   rd_bits[0] = sw_i;
      A_FIQ_STAT: rd_bits = level_i & fiq_mask_i;
      A_FIQ_RAW:  rd_bits = level_i;
      A_FIQ_EN:   rd_bits = fiq_mask_i;
      default:    rd_ok = 1'b0;
    endcase
    rd_val         = '0;
    rd_val[N-1:0]  = rd_bits;
  end

  always_comb begin
    wr_ok     = 1'b1;
    irq_set_o = 1'b0;
    irq_clr_o = 1'b0;
    fiq_set_o = 1'b0;
    fiq_clr_o = 1'b0;
    sw_set_o  = 1'b0;
    sw_clr_o  = 1'b0;
    case (addr_i)
      A_IRQ_EN:  irq_set_o = wr_en_i;
      A_IRQ_CLR: irq_clr_o = wr_en_i;
      A_FIQ_EN:  fiq_set_o = wr_en_i;
      A_FIQ_CLR: fiq_clr_o = wr_en_i;
      A_SW_SET:  sw_set_o  = wr_en_i & wdata_i[0];
      A_SW_CLR:  sw_clr_o  = wr_en_i & wdata_i[0];
      default:   wr_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (wr_en_i & ~wr_ok) | (rd_act & ~rd_ok);
      if (rd_act) rdata_q <= rd_ok ? rd_val : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/intc_dual.sv
module intc_dual
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [N_SRC-1:0] level_w;
  logic             sw_w;
  logic [N_SRC-1:0] irq_mask_w, fiq_mask_w;
  logic             irq_set, irq_clr, fiq_set, fiq_clr, sw_set, sw_clr;
  logic [NUM_PATH-1:0]            set_v, clr_v, req_v;
  logic [NUM_PATH-1:0][N_SRC-1:0] mask_v;

  intc_level #(.N(N_SRC)) u_level (
    .clk_i, .rst_ni, .src_i,
    .sw_set_i (sw_set),
    .sw_clr_i (sw_clr),
    .level_o  (level_w),
    .sw_o     (sw_w)
  );

  assign set_v = {fiq_set, irq_set};
  assign clr_v = {fiq_clr, irq_clr};

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    intc_mask #(.N(N_SRC)) u_mask (
      .clk_i, .rst_ni,
      .set_i  (set_v[p]),
      .clr_i  (clr_v[p]),
      .bits_i (wdata_i[N_SRC-1:0]),
      .mask_o (mask_v[p])
    );
    assign req_v[p] = |(level_w & mask_v[p]);
  end

  assign irq_mask_w = mask_v[0];
  assign fiq_mask_w = mask_v[1];
  assign irq_o      = req_v[0];
  assign fiq_o      = req_v[1];

  intc_regif #(.N(N_SRC), .DW(DATA_W)) u_regif (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .level_i    (level_w),
    .irq_mask_i (irq_mask_w),
    .fiq_mask_i (fiq_mask_w),
    .sw_i       (sw_w),
    .irq_set_o  (irq_set),
    .irq_clr_o  (irq_clr),
    .fiq_set_o  (fiq_set),
    .fiq_clr_o  (fiq_clr),
    .sw_set_o   (sw_set),
    .sw_clr_o   (sw_clr),
    .rdata_o, .err_o
  );
endmodule

// File: rtl/intc_dual_chk.sv
module intc_dual_chk
  import intc_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [3:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          err_o,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [N-1:0]  irq_mask,
  input logic [N-1:0]  fiq_mask,
  input logic          sw
);
  assert_irq_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask == '0) |-> !irq_o);
  assert_fiq_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_mask == '0) |-> !fiq_o);
  assert_irq_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IRQ_EN) |=>
      ((irq_mask & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));
  assert_fiq_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_FIQ_CLR) |=> ((fiq_mask & $past(wdata_i[N-1:0])) == '0));
  assert_sw_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_SW_SET && wdata_i[0]) |=> sw);
  assert_err_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == A_IRQ_STAT || addr_i == A_FIQ_RAW)) |=> err_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IRQ_RAW) |=> ($stable(irq_mask) && $stable(fiq_mask)));
endmodule

bind intc_dual intc_dual_chk #(.N(N_SRC), .DW(DATA_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .err_o, .irq_o, .fiq_o,
  .irq_mask (irq_mask_w),
  .fiq_mask (fiq_mask_w),
  .sw       (sw_w)
);

// File: tb/tb_intc_dual.sv
module tb_intc_dual;
  localparam int N = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          err, irq, fiq;

  intc_dual #(.N_SRC(N), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni, .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .irq_o(irq), .fiq_o(fiq)
  );

  always #5ns clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [N-1:0] m_src = '0, m_ien = '0, m_fen = '0;
  logic m_sw = 1'b0;
  logic [DW-1:0] m_last = '0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_lvl();
    return m_src | {{(N-1){1'b0}}, m_sw};
  endfunction

  function automatic bit wr_valid(logic [3:0] a);
    return a inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd10, 4'd11};
  endfunction

  function automatic bit rd_valid(logic [3:0] a);
    return a inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd8, 4'd9, 4'd10};
  endfunction

  function automatic logic [DW-1:0] m_read(logic [3:0] a);
    case (a)
      4'd0:       return m_lvl() & m_ien;
      4'd1, 4'd9: return m_lvl();
      4'd2:       return m_ien;
      4'd4:       return {{(DW-1){1'b0}}, m_sw};
      4'd8:       return m_lvl() & m_fen;
      4'd10:      return m_fen;
      default:    return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a, bit is_wr);
    if (is_wr ? !wr_valid(a) : !rd_valid(a)) return "R9";
    case (a)
      4'd0, 4'd8:  return "R5";
      4'd1, 4'd9:  return "R2";
      4'd3, 4'd11: return "R4";
      4'd4, 4'd5:  return "R7";
      default:     return "R3";
    endcase
  endfunction

  task automatic chk_out();
    chk("R6 irq_o", DW'(irq), DW'(|(m_lvl() & m_ien)));
    chk("R6 fiq_o", DW'(fiq), DW'(|(m_lvl() & m_fen)));
  endtask

  task automatic m_write(logic [3:0] a, logic [DW-1:0] d);
    case (a)
      4'd2:  m_ien |= d[N-1:0];
      4'd3:  m_ien &= ~d[N-1:0];
      4'd4:  if (d[0]) m_sw = 1'b1;
      4'd5:  if (d[0]) m_sw = 1'b0;
      4'd10: m_fen |= d[N-1:0];
      4'd11: m_fen &= ~d[N-1:0];
      default: ;
    endcase
  endtask

  task automatic do_write(logic [3:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(a, d);
    chk({tag_of(a, 1), " write err_o"}, DW'(err), DW'(!wr_valid(a)));
    chk_out();
  endtask

  task automatic do_read(logic [3:0] a);
    logic [DW-1:0] e;
    e = m_read(a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    m_last = e;
    chk({tag_of(a, 0), " read data (R10 timing)"}, rdata, e);
    chk({tag_of(a, 0), " read err_o"}, DW'(err), DW'(!rd_valid(a)));
  endtask

  task automatic set_src(logic [N-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
    m_src = v;
    chk_out();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #1ns;
    chk("R1 irq_o in reset", DW'(irq), '0);
    chk("R1 fiq_o in reset", DW'(fiq), '0);
    chk("R1 rdata_o in reset", rdata, '0);
    chk("R1 err_o in reset", DW'(err), '0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    do_read(4'd2);
    do_read(4'd10);
    do_read(4'd4);

    // R6: lines active but masks empty
    set_src(32'hffff_ffff);
    do_write(4'd2, 32'h0000_0010);
    do_write(4'd10, 32'h8000_0000);
    do_read(4'd0);
    do_read(4'd8);
    do_write(4'd3, 32'h0000_0010);
    do_write(4'd11, 32'hffff_ffff);
    set_src('0);

    // R7: set and clear with bit 0 low ignored
    do_write(4'd4, 32'hffff_fffe);
    do_read(4'd4);
    do_write(4'd4, 32'h1);
    do_read(4'd4);
    do_write(4'd5, 32'hffff_fffe);
    do_read(4'd4);

    // R8: shared line 0
    do_write(4'd2, 32'h1);
    do_read(4'd1);
    set_src(32'h1);
    do_write(4'd5, 32'h1);
    do_read(4'd1);
    do_read(4'd0);
    set_src('0);
    do_read(4'd9);

    // R9: invalid accesses change nothing
    do_write(4'd10, 32'h0000_ff00);
    do_write(4'd0, 32'hffff_ffff);
    do_write(4'd1, 32'hffff_ffff);
    do_write(4'd8, 32'hffff_ffff);
    do_write(4'd9, 32'hffff_ffff);
    do_write(4'd6, 32'h1);
    do_write(4'd13, 32'h1);
    do_read(4'd3);
    do_read(4'd5);
    do_read(4'd11);
    do_read(4'd15);
    do_read(4'd2);
    do_read(4'd10);

    // R10: write wins over a simultaneous read
    do_read(4'd10);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 4'd2; wdata = 32'h00f0_0000;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    m_write(4'd2, 32'h00f0_0000);
    chk("R10 read ignored with write", rdata, m_last);
    do_read(4'd2);

    // random traffic
    for (int i = 0; i < 800; i++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: set_src($urandom());
        1: do_write(4'($urandom_range(0, 15)), $urandom());
        2: do_read(4'($urandom_range(0, 15)));
        default: begin
          logic [3:0] a;
          case ($urandom_range(0, 5))
            0: a = 4'd2; 1: a = 4'd3; 2: a = 4'd4;
            3: a = 4'd5; 4: a = 4'd10; default: a = 4'd11;
          endcase
          do_write(a, $urandom() & $urandom());
        end
      endcase
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule